// File: doc/BRIEF.md
# Single-Wire LED Pulse Serializer

The block turns a byte stream into the self-timed waveform that a chain of single-wire addressable LEDs expects. Each data bit occupies one fixed-length slot. The line rises at the start of every slot, and the bit value sets how long it stays high: a short high time is a 0 and a long high time is a 1. Bytes go out most significant bit first. A configurable number of padding slots, always sent as 0 bits, can follow every byte. Pixels are three consecutive bytes. The block does not interpret them any further, because colour order and scaling are settled upstream.

Upstream sends bytes over a valid/ready handshake, with a last flag on the final byte of a frame. A one-byte holding register lets the next byte arrive while the current one is being sent. When the current byte finishes and no byte is waiting, the line stays low while the block waits, which is a stall. If the stall goes on longer than the latch interval, the chain would treat the gap as a latch, so the block abandons the frame. Every frame, whether completed or abandoned, ends with the line held low for the latch interval. During that interval the input is not ready. A one-cycle done pulse reports the outcome and the number of cycles the frame took.

The controller has four states. IDLE waits for a first byte. SEND times the slots. STALL waits for a late byte. LATCH holds the line low. The transitions are:
- start: IDLE to SEND, when a byte is held.
- next byte: SEND to SEND, when a byte is held at the end of a byte.
- underrun: SEND to STALL, when nothing is held at the end of a byte.
- resume: STALL to SEND, when a byte arrives.
- abort: STALL to LATCH, when the stall limit is reached.
- finish: SEND to LATCH, at the end of the last byte.
- release: LATCH to IDLE, when the latch interval has elapsed.

Top module: `led_wire_serializer`

## Requirements
- R1: During and after a synchronous active-high reset, led_out is 0, in_ready is 1, frame_done is 0, frame_aborted is 0 and frame_cycles is 0.
- R2: Every bit slot lasts T1_CYC+T2_CYC+T3_CYC cycles. led_out rises in the first cycle of each slot. Within an uninterrupted frame, consecutive rising edges are exactly one slot apart.
- R3: A 0 bit holds led_out high for exactly T1_CYC cycles and then low for the rest of the slot.
- R4: A 1 bit holds led_out high for exactly T1_CYC+T2_CYC cycles and then low for the rest of the slot.
- R5: Bytes are sent in stream order, each with bit 7 first and bit 0 last.
- R6: Each byte is followed by EXTRA_SLOTS padding slots that carry 0 bits, so a byte takes DATA_W+EXTRA_SLOTS slots.
- R7: A frame ends after the byte that carried in_last=1. frame_done is then high for exactly one cycle, and in_ready stays 0 for exactly WAIT_US*CLK_PER_US cycles, counted from the frame_done cycle, with led_out held at 0.
- R8: frame_cycles, sampled with frame_done, equals the number of cycles from the first slot cycle to the last send or stall cycle. Without stalls this is bytes*(DATA_W+EXTRA_SLOTS)*slot length.
- R9: If no byte is held when a byte ends, led_out stays 0 until one arrives. Sending then continues with that byte, the stall cycles add to frame_cycles, and frame_aborted stays 0.
- R10: If a stall reaches WAIT_US*CLK_PER_US+1 cycles without a byte, the frame ends with frame_done=1 and frame_aborted=1, led_out stays 0, and the latch interval follows.
- R11: After the latch interval, including one that follows an abort, the next byte starts a fresh frame whose timing and frame_cycles match R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_last | input | 1 | Offered byte is the last of the frame |
| in_ready | output | 1 | Byte is accepted when in_valid and in_ready are both high |
| led_out | output | 1 | Serial line to the LED chain |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| frame_aborted | output | 1 | Frame ended by the stall limit; valid with frame_done |
| frame_cycles | output | CNT_W | Cycles the frame took; valid with frame_done |

## Verification
The bench sweeps the arrival delay of the second byte of a two-byte frame across the point where the holding register runs dry. Stall lengths run from none to one cycle short of the limit. This catches an off-by-one in the underrun path, which would either abort a frame that should survive or miscount its cycles. Frames that end without a last flag push the stall to the limit, which catches a design that never aborts or aborts one cycle late. Frames of all-zero and all-one bytes, plus mixed patterns of several lengths, separate the two high times and check bit order and padding slots. An inverted shift direction, a padding slot sent as 1, or a shortened slot would each show up as a wrong decoded bit or an irregular rise spacing. The latch interval is measured after every frame, and a normal frame follows an aborted one, so leftover state from an abort would be caught.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_STALL = 2'd2,
        ST_LATCH = 2'd3
    } ser_state_t;

endpackage

// File: rtl/led_ser_hold.sv
module led_ser_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    input  logic          din_last,
    output logic          full,
    output logic [DW-1:0] dout,
    output logic          dout_last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            dout      <= '0;
            dout_last <= 1'b0;
        end else if (push) begin
            full      <= 1'b1;
            dout      <= din;
            dout_last <= din_last;
        end else if (pop) begin
            full      <= 1'b0;
        end
    end

endmodule

// File: rtl/led_ser_bitgen.sv
module led_ser_bitgen #(
    parameter int DW    = 8,
    parameter int T1    = 2,
    parameter int T2    = 3,
    parameter int T3    = 2,
    parameter int EXTRA = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [DW-1:0] din,
    output logic          level,
    output logic          byte_end
);

    localparam int SLOT = T1 + T2 + T3;
    localparam int BITS = DW + EXTRA;
    localparam int SW   = $clog2(SLOT + 1);
    localparam int BW   = $clog2(BITS + 1);
    localparam logic [SW-1:0] SLOT_END = SW'(SLOT - 1);
    localparam logic [SW-1:0] HI_ZERO  = SW'(T1);
    localparam logic [SW-1:0] HI_ONE   = SW'(T1 + T2);
    localparam logic [BW-1:0] BIT_END  = BW'(BITS - 1);

    logic [DW-1:0] shreg;
    logic [SW-1:0] slot_cnt;
    logic [BW-1:0] bit_idx;
    logic          slot_last;
    logic          bit_last;

    assign slot_last = (slot_cnt == SLOT_END);
    assign bit_last  = (bit_idx == BIT_END);
    assign byte_end  = run && slot_last && bit_last;

    // the shifter fills with zeros, so padding slots after the data bits are 0 bits
    assign level = run && (slot_cnt < (shreg[DW-1] ? HI_ONE : HI_ZERO));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            slot_cnt <= '0;
            bit_idx  <= '0;
        end else if (load) begin
            shreg    <= din;
            slot_cnt <= '0;
            bit_idx  <= '0;
        end else if (run) begin
            if (slot_last) begin
                slot_cnt <= '0;
                if (!bit_last) begin
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {shreg[DW-2:0], 1'b0};
                end
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/led_ser_tick.sv
module led_ser_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (en)    count <= count + 1'b1;
    end

endmodule

// File: rtl/led_wire_serializer.sv
module led_wire_serializer
    import led_ser_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int T1_CYC      = 25,
    parameter int T2_CYC      = 50,
    parameter int T3_CYC      = 50,
    parameter int EXTRA_SLOTS = 0,
    parameter int WAIT_US     = 50,
    parameter int CLK_PER_US  = 100,
    parameter int CNT_W       = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              led_out,
    output logic              frame_done,
    output logic              frame_aborted,
    output logic [CNT_W-1:0]  frame_cycles
);

    localparam int WAIT_CYC = WAIT_US * CLK_PER_US;
    localparam logic [CNT_W-1:0] LATCH_END = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] ABORT_AT  = CNT_W'(WAIT_CYC);

    ser_state_t state, state_nx;

    logic              hold_full, hold_last, hold_push, hold_pop;
    logic [DATA_W-1:0] hold_data;
    logic              cur_last;
    logic              load;
    logic              byte_end;
    logic              level;
    logic [CNT_W-1:0]  cyc_cnt, stall_cnt, latch_cnt;
    logic              ending;

    assign in_ready  = !hold_full &&
                       ((state == ST_IDLE) ||
                        ((state == ST_SEND || state == ST_STALL) && !cur_last));
    assign hold_push = in_valid && in_ready;
    assign hold_pop  = load;

    led_ser_hold #(.DW(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .push(hold_push), .pop(hold_pop),
        .din(in_data), .din_last(in_last),
        .full(hold_full), .dout(hold_data), .dout_last(hold_last)
    );

    led_ser_bitgen #(
        .DW(DATA_W), .T1(T1_CYC), .T2(T2_CYC), .T3(T3_CYC), .EXTRA(EXTRA_SLOTS)
    ) u_bits (
        .clk(clk), .rst(rst), .load(load), .run(state == ST_SEND),
        .din(hold_data), .level(level), .byte_end(byte_end)
    );

    led_ser_tick #(.W(CNT_W)) u_cyc (
        .clk(clk), .rst(rst), .clr(state == ST_IDLE),
        .en(state == ST_SEND || state == ST_STALL), .count(cyc_cnt)
    );

    led_ser_tick #(.W(CNT_W)) u_stall (
        .clk(clk), .rst(rst), .clr(state != ST_STALL),
        .en(state == ST_STALL), .count(stall_cnt)
    );

    led_ser_tick #(.W(CNT_W)) u_latch (
        .clk(clk), .rst(rst), .clr(state != ST_LATCH),
        .en(state == ST_LATCH), .count(latch_cnt)
    );

    // next-state and control decode
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hold_full) begin
                    load     = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (byte_end) begin
                    if (cur_last) begin
                        state_nx = ST_LATCH;
                    end else if (hold_full) begin
                        load = 1'b1;
                    end else begin
                        state_nx = ST_STALL;
                    end
                end
            end
            ST_STALL: begin
                if (hold_full) begin
                    load     = 1'b1;
                    state_nx = ST_SEND;
                end else if (stall_cnt == ABORT_AT) begin
                    state_nx = ST_LATCH;
                end
            end
            ST_LATCH: begin
                if (latch_cnt == LATCH_END) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign ending = (state == ST_SEND || state == ST_STALL) && (state_nx == ST_LATCH);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_last <= 1'b0;
        end else begin
            state <= state_nx;
            if (load) cur_last <= hold_last;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_done    <= 1'b0;
            frame_aborted <= 1'b0;
            frame_cycles  <= '0;
        end else begin
            frame_done <= ending;
            if (ending) begin
                frame_aborted <= (state == ST_STALL);
                frame_cycles  <= cyc_cnt + 1'b1;
            end
        end
    end

    assign led_out = level;

endmodule

// File: rtl/led_ser_chk.sv
module led_ser_chk #(
    parameter int T1 = 2,
    parameter int T2 = 3,
    parameter int T3 = 2
) (
    input logic clk,
    input logic rst,
    input logic led_out,
    input logic in_ready,
    input logic frame_done,
    input logic frame_aborted
);

    localparam logic [15:0] LEN0 = 16'(T1);
    localparam logic [15:0] LEN1 = 16'(T1 + T2);
    localparam logic [15:0] SLOT = 16'(T1 + T2 + T3);

    logic [15:0] hi_len;
    logic [15:0] rise_gap;
    logic        led_d;
    logic        rise_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len    <= '0;
            rise_gap  <= '0;
            led_d     <= 1'b0;
            rise_seen <= 1'b0;
        end else begin
            led_d  <= led_out;
            hi_len <= led_out ? hi_len + 1'b1 : 16'd0;
            if (led_out && !led_d) begin
                rise_gap  <= 16'd1;
                rise_seen <= 1'b1;
            end else if (rise_gap != 16'hFFFF) begin
                rise_gap <= rise_gap + 1'b1;
            end
        end
    end

    // R3 R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!led_out && led_d) |-> (hi_len == LEN0 || hi_len == LEN1));

    // R2
    slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (led_out && !led_d && rise_seen) |-> (rise_gap >= SLOT));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!led_out && !in_ready));

    // R10
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_aborted) |-> frame_done);

endmodule

bind led_wire_serializer led_ser_chk #(
    .T1(T1_CYC), .T2(T2_CYC), .T3(T3_CYC)
) u_chk (
    .clk(clk), .rst(rst), .led_out(led_out), .in_ready(in_ready),
    .frame_done(frame_done), .frame_aborted(frame_aborted)
);

// File: tb/sim_led_wire_serializer.sv
`timescale 1ns/1ps
module sim_led_wire_serializer;

    localparam int DW = 8;
    localparam int T1 = 2;
    localparam int T2 = 3;
    localparam int T3 = 2;
    localparam int EX = 1;
    localparam int WU = 2;
    localparam int CPU = 5;
    localparam int CW = 16;
    localparam int SLOT = T1 + T2 + T3;
    localparam int BITS = DW + EX;
    localparam int BYTE_CYC = SLOT * BITS;
    localparam int WAIT_CYC = WU * CPU;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic          in_ready, led_out, frame_done, frame_aborted;
    logic [CW-1:0] frame_cycles;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    led_wire_serializer #(
        .DATA_W(DW), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3), .EXTRA_SLOTS(EX),
        .WAIT_US(WU), .CLK_PER_US(CPU), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .led_out(led_out),
        .frame_done(frame_done), .frame_aborted(frame_aborted),
        .frame_cycles(frame_cycles)
    );

    // ---------------- monitor ----------------
    bit   mon_bits [0:1023];
    int   nbits, n_short, n_long, bad_len, bad_gap;
    int   hi_run;
    int   ncyc;
    int   last_rise;
    bit   rise_seen;
    bit   prev_led;
    bit   in_frame;
    int   meas, got_meas;
    int   got_cyc;
    bit   got_abort;
    bit   wait_active, wait_fin;
    int   wait_len, got_wait;

    always @(negedge clk) begin
        ncyc++;
        if (!rst) begin
            if (led_out) begin
                hi_run++;
                if (!prev_led) begin
                    if (rise_seen && (ncyc - last_rise) != SLOT) bad_gap++;
                    last_rise = ncyc;
                    rise_seen = 1'b1;
                end
            end else if (hi_run > 0) begin
                mon_bits[nbits] = (hi_run == T1 + T2);
                nbits++;
                if (hi_run == T1) n_short++;
                else if (hi_run == T1 + T2) n_long++;
                else bad_len++;
                hi_run = 0;
            end
            prev_led = led_out;

            if (!in_frame && led_out) begin
                in_frame = 1'b1;
                meas = 1;
            end else if (in_frame && !frame_done) begin
                meas++;
            end
            if (frame_done) begin
                got_meas    = meas;
                in_frame    = 1'b0;
                got_cyc     = int'(frame_cycles);
                got_abort   = frame_aborted;
                wait_active = 1'b1;
                wait_len    = 0;
            end
            if (wait_active) begin
                if (!in_ready) wait_len++;
                else begin
                    wait_active = 1'b0;
                    got_wait    = wait_len;
                    wait_fin    = 1'b1;
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] b, input bit last);
        in_data  = b;
        in_last  = last;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    logic [DW-1:0] exp_bytes [0:63];

    // gap_at: byte index preceded by gap_d extra negedges (-1 for none)
    task automatic run_frame(input int n, input int seed, input int gap_at,
                             input int gap_d, input bit with_last, input string tag);
        int exp_cyc, mism, pad_bad, ones, zeros, stall;
        nbits = 0; n_short = 0; n_long = 0; bad_len = 0; bad_gap = 0;
        rise_seen = 1'b0; wait_fin = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (seed == -1)      exp_bytes[i] = 8'h00;
            else if (seed == -2) exp_bytes[i] = 8'hFF;
            else                 exp_bytes[i] = 8'((seed * 53 + i * 29 + 7) & 255);
        end
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) repeat (gap_d) @(negedge clk);
            push(exp_bytes[i], with_last && (i == n - 1));
        end
        while (!wait_fin) @(negedge clk);

        stall = (gap_at == 1 && gap_d > 62) ? gap_d - 62 : 0;
        exp_cyc = n * BYTE_CYC + stall + (with_last ? 0 : WAIT_CYC + 1);

        mism = 0; pad_bad = 0; ones = 0; zeros = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < BITS; j++) begin
                bit e;
                e = (j < DW) ? exp_bytes[i][DW-1-j] : 1'b0;
                if (e) ones++; else zeros++;
                if (mon_bits[i*BITS + j] != e) begin
                    if (j < DW) mism++; else pad_bad++;
                end
            end
        end
        // R5 bit order, R6 padding
        chk(mism == 0, {tag, " R5 bit order mismatches"}, mism, 0);
        chk(nbits == n * BITS && pad_bad == 0, {tag, " R6 slot count"}, nbits, n * BITS);
        // R3 / R4 pulse widths
        chk(n_short == zeros && bad_len == 0, {tag, " R3 short pulses"}, n_short, zeros);
        chk(n_long == ones && bad_len == 0, {tag, " R4 long pulses"}, n_long, ones);
        if (stall == 0 && with_last)
            chk(bad_gap == 0, {tag, " R2 slot spacing"}, bad_gap, 0);
        // R8 cycle report
        chk(got_cyc == exp_cyc, {tag, " R8 frame_cycles"}, got_cyc, exp_cyc);
        chk(got_meas == got_cyc, {tag, " R8 measured length"}, got_meas, got_cyc);
        // R7 latch interval
        chk(got_wait == WAIT_CYC, {tag, " R7 latch interval"}, got_wait, WAIT_CYC);
        // R9 / R10 abort flag
        if (with_last)
            chk(got_abort == 1'b0, {tag, " R9 no abort"}, int'(got_abort), 0);
        else
            chk(got_abort == 1'b1, {tag, " R10 abort flagged"}, int'(got_abort), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(led_out == 1'b0, "R1 led_out in reset", int'(led_out), 0);
        chk(frame_done == 1'b0, "R1 frame_done in reset", int'(frame_done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(led_out == 1'b0, "R1 led_out idle", int'(led_out), 0);
        chk(in_ready == 1'b1, "R1 in_ready idle", int'(in_ready), 1);
        chk(frame_cycles == '0 && frame_aborted == 1'b0, "R1 report cleared",
            int'(frame_cycles), 0);

        run_frame(1, 3, -1, 0, 1'b1, "single");
        run_frame(3, -1, -1, 0, 1'b1, "zeros");
        run_frame(3, -2, -1, 0, 1'b1, "ones");
        for (int s = 0; s < 4; s++) run_frame(3 * (s + 1), s + 11, -1, 0, 1'b1, "mixed");

        // R9 stall sweep around the point where the holding register runs dry
        for (int d = 58; d <= 73; d++) run_frame(2, d, 1, d, 1'b1, "R9 stall");

        // R10 abort: frames with no last flag
        run_frame(1, 40, -1, 0, 1'b0, "R10 abort1");
        run_frame(4, 41, -1, 0, 1'b0, "R10 abort4");
        // R11 fresh frame after an abort
        run_frame(3, 42, -1, 0, 1'b1, "R11 after abort");

        repeat (5) @(negedge clk);
        chk(led_out == 1'b0 && in_ready == 1'b1, "R11 back to idle", int'(led_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule